// File: doc/BRIEF.md
# Data-Space Address Generator and Decoder

This block sits in the load/store path of a small 8-bit processor core. From a requested addressing mode it forms the effective data-memory address. That address is either a direct 16-bit value or one of three 16-bit pointers, possibly offset, decremented or incremented. When the mode changes the pointer, the block also produces the new pointer value and a write strobe aimed at that pointer. Finally it decodes the effective address into one of four contiguous regions: working registers, standard I/O, extended I/O and SRAM. It reports a one-hot region select and the offset inside the selected region.

The pointer registers themselves, the register file, the I/O registers and the memories live outside the block. The three pointer values come in as ports and the write-back goes out as ports. All results are registered once, so they appear one clock after the request. Requests that cannot be executed are flagged rather than silently mapped. An address above the end of SRAM is flagged as well.

Top module: `dspace_agu`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is zero.
- R2: Outputs are registered: a request sampled on one rising edge shows up after that edge; in a cycle without `req_valid` the next result has `out_valid` low and every other output zero.
- R3: Mode code 0 (direct) yields `eff_addr` equal to `req_direct` with no pointer write-back, whatever `req_ptr_sel` holds.
- R4: Mode code 1 (indirect) yields the selected pointer as address (selector 0 = X, 1 = Y, 2 = Z) with no write-back.
- R5: Mode code 2 (displacement), allowed with Y or Z only, yields pointer plus the zero-extended 6-bit displacement (0 to 63), modulo 2^16, with no write-back.
- R6: Mode code 3 (pre-decrement) yields pointer minus 1 modulo 2^16 as address and writes that same value back to the selected pointer (`ptr_wr_sel` equals the selector).
- R7: Mode code 4 (post-increment) yields the unmodified pointer as address and writes pointer plus 1 modulo 2^16 back to the selected pointer.
- R8: Displacement mode with X, selector 3 in any pointer mode, and mode codes 5 to 7 raise `illegal_mode`; the address, write-back, region select and offset are then all zero.
- R9: `region_sel` is one-hot with bit 0 for registers (0x0000-0x001F), bit 1 for standard I/O (0x0020-0x005F), bit 2 for extended I/O (0x0060-0x00FF) and bit 3 for SRAM (0x0100 up to 0x0100 plus the SRAM size minus 1).
- R10: `region_offset` equals the effective address minus the base of the selected region.
- R11: An address at or above the end of SRAM raises `out_of_range`, selects no region and gives offset zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Addressing mode code |
| req_ptr_sel | input | 2 | Pointer selector (0 X, 1 Y, 2 Z) |
| req_direct | input | 16 | Direct address |
| req_disp | input | 6 | Displacement |
| x_ptr | input | 16 | Current X pointer |
| y_ptr | input | 16 | Current Y pointer |
| z_ptr | input | 16 | Current Z pointer |
| out_valid | output | 1 | Result valid |
| eff_addr | output | 16 | Effective address |
| ptr_wr_en | output | 1 | Pointer write-back strobe |
| ptr_wr_sel | output | 2 | Pointer to be written |
| ptr_wr_data | output | 16 | New pointer value |
| region_sel | output | 4 | One-hot region select |
| region_offset | output | 16 | Offset inside the selected region |
| out_of_range | output | 1 | Address past the end of SRAM |
| illegal_mode | output | 1 | Request cannot be executed |

## Verification
The bench builds the block with a 512-byte SRAM instead of the default 1024. This places the end of the data space at 0x0300, so the out-of-range border can be approached from both sides with short pointer walks. The other region sizes keep their defaults. Pre-decrement from zero and post-increment from 0xFFFF are therefore able to test the 16-bit wrap together with the out-of-range flag.

// File: rtl/dspace_agu_pkg.sv
package dspace_agu_pkg;

   typedef enum logic [2:0] {
      AM_DIRECT  = 3'd0,
      AM_IND     = 3'd1,
      AM_DISP    = 3'd2,
      AM_PREDEC  = 3'd3,
      AM_POSTINC = 3'd4
   } amode_e;

   typedef enum logic [1:0] {
      PS_X    = 2'd0,
      PS_Y    = 2'd1,
      PS_Z    = 2'd2,
      PS_NONE = 2'd3
   } psel_e;

   localparam int NUM_REGIONS = 4;

endpackage

// File: rtl/dspace_agu_ptr_mux.sv
module dspace_agu_ptr_mux #(
   parameter int AW = 16
) (
   input  logic [1:0]    sel,
   input  logic [AW-1:0] x_val,
   input  logic [AW-1:0] y_val,
   input  logic [AW-1:0] z_val,
   output logic [AW-1:0] ptr,
   output logic          sel_ok
);
   import dspace_agu_pkg::*;

   always_comb begin
      sel_ok = 1'b1;
      case (sel)
         PS_X:    ptr = x_val;
         PS_Y:    ptr = y_val;
         PS_Z:    ptr = z_val;
         default: begin
            ptr    = '0;
            sel_ok = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/dspace_agu_calc.sv
module dspace_agu_calc #(
   parameter int AW     = 16,
   parameter int DISP_W = 6
) (
   input  logic [2:0]        mode,
   input  logic [1:0]        sel,
   input  logic              sel_ok,
   input  logic [AW-1:0]     ptr,
   input  logic [AW-1:0]     direct,
   input  logic [DISP_W-1:0] disp,
   output logic [AW-1:0]     ea,
   output logic              wr_en,
   output logic [1:0]        wr_sel,
   output logic [AW-1:0]     wr_data,
   output logic              illegal
);
   import dspace_agu_pkg::*;

   localparam logic [AW-1:0] ONE = AW'(1);

   logic [AW-1:0] disp_ext;
   logic [AW-1:0] ptr_dec;
   logic [AW-1:0] ptr_inc;

   assign disp_ext = AW'(disp);
   assign ptr_dec  = ptr - ONE;
   assign ptr_inc  = ptr + ONE;

   always_comb begin
      ea      = '0;
      wr_en   = 1'b0;
      wr_sel  = 2'd0;
      wr_data = '0;
      illegal = 1'b0;
      case (mode)
         AM_DIRECT: ea = direct;
         AM_IND: begin
            if (sel_ok) ea = ptr;
            else        illegal = 1'b1;
         end
         AM_DISP: begin
            if (sel_ok && sel != PS_X) ea = ptr + disp_ext;
            else                       illegal = 1'b1;
         end
         AM_PREDEC: begin
            if (sel_ok) begin
               ea      = ptr_dec;
               wr_en   = 1'b1;
               wr_sel  = sel;
               wr_data = ptr_dec;
            end else begin
               illegal = 1'b1;
            end
         end
         AM_POSTINC: begin
            if (sel_ok) begin
               ea      = ptr;
               wr_en   = 1'b1;
               wr_sel  = sel;
               wr_data = ptr_inc;
            end else begin
               illegal = 1'b1;
            end
         end
         default: illegal = 1'b1;
      endcase
   end
endmodule

// File: rtl/dspace_agu_region.sv
module dspace_agu_region #(
   parameter int AW     = 16,
   parameter int RF_N   = 32,
   parameter int IO_N   = 64,
   parameter int XIO_N  = 160,
   parameter int SRAM_N = 1024
) (
   input  logic          blk,
   input  logic [AW-1:0] addr,
   output logic [3:0]    sel,
   output logic [AW-1:0] offset,
   output logic          oor
);
   import dspace_agu_pkg::*;

   localparam int SIZES [NUM_REGIONS] = '{RF_N, IO_N, XIO_N, SRAM_N};

   function automatic int base_of(int idx);
      int acc = 0;
      for (int k = 0; k < idx; k++) acc += SIZES[k];
      return acc;
   endfunction

   logic [AW:0]   addr_x;
   logic [AW-1:0] offs [NUM_REGIONS];
   logic [NUM_REGIONS-1:0] hit;

   assign addr_x = {1'b0, addr};

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
      localparam logic [AW:0] LO = (AW+1)'(base_of(g));
      localparam logic [AW:0] HI = (AW+1)'(base_of(g) + SIZES[g]);
      assign hit[g]  = !blk && (addr_x >= LO) && (addr_x < HI);
      assign offs[g] = addr - LO[AW-1:0];
   end

   always_comb begin
      offset = '0;
      for (int r = 0; r < NUM_REGIONS; r++)
         if (hit[r]) offset = offs[r];
   end

   assign sel = hit;
   assign oor = !blk && (hit == '0);
endmodule

// File: rtl/dspace_agu.sv
module dspace_agu #(
   parameter int AW     = 16,
   parameter int DISP_W = 6,
   parameter int RF_N   = 32,
   parameter int IO_N   = 64,
   parameter int XIO_N  = 160,
   parameter int SRAM_N = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_mode,
   input  logic [1:0]        req_ptr_sel,
   input  logic [AW-1:0]     req_direct,
   input  logic [DISP_W-1:0] req_disp,
   input  logic [AW-1:0]     x_ptr,
   input  logic [AW-1:0]     y_ptr,
   input  logic [AW-1:0]     z_ptr,
   output logic              out_valid,
   output logic [AW-1:0]     eff_addr,
   output logic              ptr_wr_en,
   output logic [1:0]        ptr_wr_sel,
   output logic [AW-1:0]     ptr_wr_data,
   output logic [3:0]        region_sel,
   output logic [AW-1:0]     region_offset,
   output logic              out_of_range,
   output logic              illegal_mode
);
   localparam int SPACE_END = RF_N + IO_N + XIO_N + SRAM_N;

   if (SPACE_END > (2 ** AW)) begin : g_bad_space
      $error("data space exceeds address width");
   end
   if (DISP_W >= AW) begin : g_bad_disp
      $error("displacement width must be below address width");
   end
   if (SRAM_N < 1) begin : g_bad_sram
      $error("SRAM size must be positive");
   end

   logic [AW-1:0] ptr_v;
   logic          ptr_ok;
   logic [AW-1:0] ea_c;
   logic          we_c;
   logic [1:0]    ws_c;
   logic [AW-1:0] wd_c;
   logic          ill_c;
   logic [3:0]    rs_c;
   logic [AW-1:0] off_c;
   logic          oor_c;

   dspace_agu_ptr_mux #(.AW(AW)) u_mux (
      .sel    (req_ptr_sel),
      .x_val  (x_ptr),
      .y_val  (y_ptr),
      .z_val  (z_ptr),
      .ptr    (ptr_v),
      .sel_ok (ptr_ok)
   );

   dspace_agu_calc #(.AW(AW), .DISP_W(DISP_W)) u_calc (
      .mode    (req_mode),
      .sel     (req_ptr_sel),
      .sel_ok  (ptr_ok),
      .ptr     (ptr_v),
      .direct  (req_direct),
      .disp    (req_disp),
      .ea      (ea_c),
      .wr_en   (we_c),
      .wr_sel  (ws_c),
      .wr_data (wd_c),
      .illegal (ill_c)
   );

   dspace_agu_region #(
      .AW(AW), .RF_N(RF_N), .IO_N(IO_N), .XIO_N(XIO_N), .SRAM_N(SRAM_N)
   ) u_dec (
      .blk    (ill_c),
      .addr   (ea_c),
      .sel    (rs_c),
      .offset (off_c),
      .oor    (oor_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         eff_addr      <= '0;
         ptr_wr_en     <= 1'b0;
         ptr_wr_sel    <= 2'd0;
         ptr_wr_data   <= '0;
         region_sel    <= '0;
         region_offset <= '0;
         out_of_range  <= 1'b0;
         illegal_mode  <= 1'b0;
      end else if (req_valid) begin
         out_valid     <= 1'b1;
         eff_addr      <= ea_c;
         ptr_wr_en     <= we_c;
         ptr_wr_sel    <= ws_c;
         ptr_wr_data   <= wd_c;
         region_sel    <= rs_c;
         region_offset <= off_c;
         out_of_range  <= oor_c;
         illegal_mode  <= ill_c;
      end else begin
         out_valid     <= 1'b0;
         eff_addr      <= '0;
         ptr_wr_en     <= 1'b0;
         ptr_wr_sel    <= 2'd0;
         ptr_wr_data   <= '0;
         region_sel    <= '0;
         region_offset <= '0;
         out_of_range  <= 1'b0;
         illegal_mode  <= 1'b0;
      end
   end
endmodule

// File: rtl/dspace_agu_chk.sv
module dspace_agu_chk #(
   parameter int AW     = 16,
   parameter int SRAM_N = 1024
) (
   input logic          clk,
   input logic          rst_n,
   input logic          out_valid,
   input logic [AW-1:0] eff_addr,
   input logic          ptr_wr_en,
   input logic [1:0]    ptr_wr_sel,
   input logic [AW-1:0] ptr_wr_data,
   input logic [3:0]    region_sel,
   input logic [AW-1:0] region_offset,
   input logic          out_of_range,
   input logic          illegal_mode
);
   localparam logic [AW-1:0] ONE = AW'(1);
   localparam logic [AW-1:0] SRAM_LIM = AW'(SRAM_N);

   // R2
   wb_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr_en |-> out_valid);

   // R9
   region_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(region_sel));

   // R11
   oor_no_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_of_range |-> (region_sel == 4'b0000 && region_offset == '0));

   // R8
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_mode |-> (!ptr_wr_en && region_sel == 4'b0000 && !out_of_range));

   // R6
   wb_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr_en |-> (ptr_wr_data == eff_addr || ptr_wr_data == eff_addr + ONE));

   // R6
   wb_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr_en |-> (ptr_wr_sel != 2'd3));

   // R10
   sram_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      region_sel[3] |-> (region_offset < SRAM_LIM));

   // R9
   rf_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      region_sel[0] |-> (region_offset == eff_addr));
endmodule

bind dspace_agu dspace_agu_chk #(.AW(AW), .SRAM_N(SRAM_N)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .out_valid     (out_valid),
   .eff_addr      (eff_addr),
   .ptr_wr_en     (ptr_wr_en),
   .ptr_wr_sel    (ptr_wr_sel),
   .ptr_wr_data   (ptr_wr_data),
   .region_sel    (region_sel),
   .region_offset (region_offset),
   .out_of_range  (out_of_range),
   .illegal_mode  (illegal_mode)
);

// File: tb/sim_dspace_agu.sv
module sim_dspace_agu;
   localparam int SRAM = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_mode = '0;
   logic [1:0]  req_ptr_sel = '0;
   logic [15:0] req_direct = '0;
   logic [5:0]  req_disp = '0;
   logic [15:0] x_ptr = '0, y_ptr = '0, z_ptr = '0;
   logic        out_valid, ptr_wr_en, out_of_range, illegal_mode;
   logic [15:0] eff_addr, ptr_wr_data, region_offset;
   logic [1:0]  ptr_wr_sel;
   logic [3:0]  region_sel;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   dspace_agu #(.SRAM_N(SRAM)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_ptr_sel(req_ptr_sel), .req_direct(req_direct), .req_disp(req_disp),
      .x_ptr(x_ptr), .y_ptr(y_ptr), .z_ptr(z_ptr), .out_valid(out_valid),
      .eff_addr(eff_addr), .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel),
      .ptr_wr_data(ptr_wr_data), .region_sel(region_sel),
      .region_offset(region_offset), .out_of_range(out_of_range),
      .illegal_mode(illegal_mode)
   );

   // packed: valid, ea, we, wsel, wdata, region, offset, oor, ill
   function automatic logic [57:0] model(logic v, logic [2:0] m, logic [1:0] s,
         logic [15:0] d, logic [5:0] dp, logic [15:0] x, logic [15:0] y, logic [15:0] z);
      logic [15:0] p, ea, wd, off;
      logic        ill, we, oor;
      logic [1:0]  ws;
      logic [3:0]  rg;
      if (!v) return '0;
      p  = (s == 0) ? x : (s == 1) ? y : (s == 2) ? z : 16'h0;
      ill = (m > 3'd4) || (m != 3'd0 && s == 2'd3) || (m == 3'd2 && s == 2'd0);
      ea = 0; we = 0; ws = 0; wd = 0; rg = 0; off = 0; oor = 0;
      if (!ill) begin
         case (m)
            3'd0: ea = d;
            3'd1: ea = p;
            3'd2: ea = p + {10'd0, dp};
            3'd3: begin ea = p - 16'd1; we = 1; ws = s; wd = p - 16'd1; end
            default: begin ea = p; we = 1; ws = s; wd = p + 16'd1; end
         endcase
         if (ea < 16'd32)               begin rg = 4'b0001; off = ea; end
         else if (ea < 16'd96)          begin rg = 4'b0010; off = ea - 16'd32; end
         else if (ea < 16'd256)         begin rg = 4'b0100; off = ea - 16'd96; end
         else if (ea < 16'(256 + SRAM)) begin rg = 4'b1000; off = ea - 16'd256; end
         else oor = 1;
      end
      return {1'b1, ea, we, ws, wd, rg, off, oor, ill};
   endfunction

   function automatic logic [57:0] actual();
      return {out_valid, eff_addr, ptr_wr_en, ptr_wr_sel, ptr_wr_data,
              region_sel, region_offset, out_of_range, illegal_mode};
   endfunction

   task automatic check(string req, logic [57:0] exp);
      n_chk++;
      if (actual() !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, actual(), exp);
      end
   endtask

   task automatic apply(string req, logic v, logic [2:0] m, logic [1:0] s,
         logic [15:0] d, logic [5:0] dp, logic [15:0] x, logic [15:0] y, logic [15:0] z);
      @(negedge clk);
      req_valid = v; req_mode = m; req_ptr_sel = s; req_direct = d;
      req_disp = dp; x_ptr = x; y_ptr = y; z_ptr = z;
      @(posedge clk);
      #2;
      check(req, model(v, m, s, d, dp, x, y, z));
   endtask

   function automatic logic [15:0] pick_addr();
      case ($urandom % 4)
         0: return 16'($urandom % 1024);
         1: return 16'(16'hFFC0 + ($urandom % 64));
         2: return 16'(752 + ($urandom % 32));
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin
      void'($urandom(32'h5EED_0042));
      // R1: reset state, then first cycle after release without a request
      repeat (3) @(posedge clk);
      #2 check("R1", '0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk);
      #2 check("R1", '0);

      // R3: direct, selector ignored; region borders R9 R10 R11
      apply("R3", 1, 3'd0, 2'd3, 16'h001F, 6'd0, 0, 0, 0);
      apply("R9", 1, 3'd0, 2'd0, 16'h0020, 6'd0, 0, 0, 0);
      apply("R10", 1, 3'd0, 2'd1, 16'h005F, 6'd0, 0, 0, 0);
      apply("R9", 1, 3'd0, 2'd2, 16'h0060, 6'd0, 0, 0, 0);
      apply("R10", 1, 3'd0, 2'd0, 16'h00FF, 6'd0, 0, 0, 0);
      apply("R9", 1, 3'd0, 2'd0, 16'h0100, 6'd0, 0, 0, 0);
      apply("R10", 1, 3'd0, 2'd0, 16'h02FF, 6'd0, 0, 0, 0);
      apply("R11", 1, 3'd0, 2'd0, 16'h0300, 6'd0, 0, 0, 0);
      apply("R11", 1, 3'd0, 2'd0, 16'hFFFF, 6'd0, 0, 0, 0);
      // R4: indirect on each pointer
      apply("R4", 1, 3'd1, 2'd0, 16'h0, 6'd0, 16'h0011, 16'h0222, 16'h0044);
      apply("R4", 1, 3'd1, 2'd2, 16'h0, 6'd0, 16'h0011, 16'h0222, 16'h0044);
      // R5: displacement max and wrap
      apply("R5", 1, 3'd2, 2'd1, 16'h0, 6'd63, 0, 16'h00C1, 0);
      apply("R5", 1, 3'd2, 2'd2, 16'h0, 6'd63, 0, 0, 16'hFFF0);
      // R6: pre-decrement from zero wraps to out of range; into border
      apply("R6", 1, 3'd3, 2'd0, 16'h0, 6'd0, 16'h0000, 0, 0);
      apply("R6", 1, 3'd3, 2'd2, 16'h0, 6'd0, 0, 0, 16'h0300);
      // R7: post-increment at top and at border
      apply("R7", 1, 3'd4, 2'd1, 16'h0, 6'd0, 0, 16'hFFFF, 0);
      apply("R7", 1, 3'd4, 2'd0, 16'h0, 6'd0, 16'h02FF, 0, 0);
      // R8: illegal requests
      apply("R8", 1, 3'd2, 2'd0, 16'h0, 6'd5, 16'h0040, 0, 0);
      apply("R8", 1, 3'd3, 2'd3, 16'h0, 6'd0, 0, 0, 0);
      apply("R8", 1, 3'd6, 2'd1, 16'h0, 6'd0, 0, 16'h0050, 0);
      // R2: idle cycle clears outputs
      apply("R2", 0, 3'd4, 2'd1, 16'h0, 6'd0, 0, 16'h0100, 0);

      for (int i = 0; i < 600; i++) begin
         apply("R2-rand", ($urandom % 8) != 0, 3'($urandom % 8), 2'($urandom % 4),
               pick_addr(), 6'($urandom), pick_addr(), pick_addr(), pick_addr());
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule